// File: doc/BRIEF.md
# Two-Register Serial Host Port with Interrupt Merge

This block is a serial-peripheral slave. It gives an external host access to two 8-bit host registers. Every access is a fixed two-byte frame sent under an active-low chip select. The first byte is a command that picks the register and the direction. The second byte carries the data, either into the chosen register or back out of it. The serial inputs are oversampled by the system clock, so all state lives in one clock domain. The serial clock has to run well below the system clock, at about one eighth of it or slower.

The block also merges four event sources into a single active-low interrupt line:

- receive queue near full
- transmit queue near empty
- receive queue holding data
- a latched status event

The pending sources show in the low nibble of register 1. A per-source enable mask sits in its high nibble. The queue level flags come in as plain inputs. Register 0 is a plain data register whose contents are presented to the surrounding logic.

Top module: `spi_hostreg_if`

## Requirements
- R1: After reset, register 0 reads 0x00, the enable mask (register 1 bits 7:4) is 0xF, no flag is pending, the interrupt output is high and the serial output driver is off.
- R2: A frame whose command byte is 0x00 (bit 7 = 0 selects register 0, bit 6 = 0 means write) loads the second byte into register 0. Both bytes are sampled on rising serial-clock edges, most significant bit first.
- R3: A frame with command 0x40 (bit 6 = 1 means read) returns register 0 on the serial output during the data byte, most significant bit first. The output changes on falling edges and is driven for all eight data bits.
- R4: Bit 7 = 1 in the command selects register 1. A read with command 0xC0 returns {enable mask[3:0], pending[3:0]}.
- R5: The serial output driver is off while chip select is high, during the whole command byte, and during the whole of any write.
- R6: A command with any of bits 5:0 nonzero is illegal. It gives a one-cycle error pulse, the serial output is never driven for it, and its data byte changes no register.
- R7: Raising chip select before sixteen serial clocks have been received aborts the frame and leaves every register unchanged.
- R8: Pending bits 0 (receive near full), 1 (transmit near empty) and 2 (receive holding data) follow their level inputs.
- R9: Pending bit 3 latches when the status event input is high. It is cleared only by writing register 1 with data bit 3 = 1. A write with bit 3 = 0 leaves it set.
- R10: Writing register 1 loads data bits 7:4 into the enable mask. The interrupt output is low exactly when some pending bit has its enable bit set.
- R11: Each falling edge of chip select restarts the bit count, so a full frame after an aborted one is decoded correctly.
- R12: Serial clocks after the sixteenth within one chip-select window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host (mode 0) |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, high impedance when not driven |
| miso_drive_en | output | 1 | High while the block drives miso |
| irq_n | output | 1 | Active-low merged interrupt |
| cmd_err | output | 1 | One-cycle pulse on an illegal command byte |
| reg0_q | output | 8 | Current contents of register 0 |
| rx_near_full | input | 1 | Receive queue near-full level flag |
| tx_near_empty | input | 1 | Transmit queue near-empty level flag |
| rx_has_data | input | 1 | Receive queue non-empty level flag |
| status_event | input | 1 | Status event; latched into pending bit 3 |

## Verification
The bench aims at the command edge cases: an illegal command carrying a full data byte, an illegal read, a frame cut after twelve clocks, and a frame with four extra clocks. Each of these would corrupt register 0 or drive the output bus if the decoder or the counter limit were wrong. It checks that read data appears in the first data bit and shifts on falling edges. An off-by-one shift loses the top bit and returns the byte shifted by one. It also checks that the latched event survives a register-1 write with bit 3 clear, and that the mask hides a pending level flag from the interrupt pin. A design that cleared the event on any register-1 write, or that ignored the mask, fails these checks.

// File: rtl/spi2r_pkg.sv
package spi2r_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic       sel_r1;
    logic       is_read;
    logic [5:0] rsvd;
  } cmd_t;

  function automatic logic cmd_legal(cmd_t c);
    return (c.rsvd == '0);
  endfunction

  function automatic logic [BYTE_W-1:0] r1_image(logic [NUM_SRC-1:0] en,
                                                 logic [NUM_SRC-1:0] pend);
    return {en, pend};
  endfunction

  function automatic logic irq_active(logic [NUM_SRC-1:0] en,
                                      logic [NUM_SRC-1:0] pend);
    return |(en & pend);
  endfunction
endpackage

// File: rtl/spi2r_sync.sv
module spi2r_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi2r_link.sv
module spi2r_link
  import spi2r_pkg::*;
#(
  parameter int FRAME_BITS = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output cmd_t              cmd_q,
  output logic              cmd_stb,
  output logic              data_stb,
  output logic [BYTE_W-1:0] data_q,
  output logic              err_pulse,
  output logic              tx_bit,
  output logic              tx_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              sclk_rise, sclk_fall, cs_fall, active;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = cs_d & ~cs_n_s;
  assign active    = ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      cmd_q     <= '0;
      data_q    <= '0;
      cmd_stb   <= 1'b0;
      data_stb  <= 1'b0;
      err_pulse <= 1'b0;
      tx_oe     <= 1'b0;
    end else begin
      cmd_stb   <= 1'b0;
      data_stb  <= 1'b0;
      err_pulse <= 1'b0;
      if (cs_fall) begin
        cnt   <= '0;
        tx_oe <= 1'b0;
      end else if (!active) begin
        tx_oe <= 1'b0;
      end else if (sclk_rise && cnt < CNT_W'(FRAME_BITS)) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(BYTE_W - 1)) begin
          cmd_q   <= cmd_t'({rx_sh[BYTE_W-2:0], mosi_s});
          cmd_stb <= 1'b1;
        end
        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          data_q   <= {rx_sh[BYTE_W-2:0], mosi_s};
          data_stb <= 1'b1;
          tx_oe    <= 1'b0;
        end
      end else if (sclk_fall && cnt > CNT_W'(BYTE_W)
                   && cnt < CNT_W'(FRAME_BITS)) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end else if (cmd_stb) begin
        tx_sh     <= rd_data;
        tx_oe     <= cmd_q.is_read & cmd_legal(cmd_q);
        err_pulse <= ~cmd_legal(cmd_q);
      end
    end
  end

  assign tx_bit = tx_sh[BYTE_W-1];

  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
  a_r5_oe_only_legal_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> (cmd_q.is_read && cmd_legal(cmd_q) && cnt >= CNT_W'(BYTE_W)));
  a_r5_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !tx_oe);
  a_r6_err_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !tx_oe);
  a_r12_single_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |=> !data_stb);
endmodule

// File: rtl/spi2r_regs.sv
module spi2r_regs
  import spi2r_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic               wr_sel_r1,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [NUM_SRC-2:0] level_in,
  input  logic               evt_in,
  output logic [BYTE_W-1:0]  r0_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               irq_n
);
  localparam int EVT_BIT = NUM_SRC - 1;

  logic wr_r0, wr_r1, evt_clr;

  assign wr_r0   = wr_stb & ~wr_sel_r1;
  assign wr_r1   = wr_stb & wr_sel_r1;
  assign evt_clr = wr_r1 & wr_data[EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q   <= '0;
      en_q   <= '1;
      pend_q <= '0;
      irq_n  <= 1'b1;
    end else begin
      if (wr_r0) r0_q <= wr_data;
      if (wr_r1) en_q <= wr_data[BYTE_W-1 -: NUM_SRC];
      pend_q[EVT_BIT-1:0] <= level_in;
      if (evt_in)       pend_q[EVT_BIT] <= 1'b1;
      else if (evt_clr) pend_q[EVT_BIT] <= 1'b0;
      irq_n <= ~irq_active(en_q, pend_q);
    end
  end

  a_r9_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[EVT_BIT] && !evt_clr) |=> pend_q[EVT_BIT]);
  a_r9_evt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !evt_in) |=> !pend_q[EVT_BIT]);
  a_r2_r0_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_r0 |=> (r0_q == $past(wr_data)));
  a_r7_r0_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_r0 |=> $stable(r0_q));
endmodule

// File: rtl/spi_hostreg_if.sv
module spi_hostreg_if
  import spi2r_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_drive_en,
  output logic              irq_n,
  output logic              cmd_err,
  output logic [BYTE_W-1:0] reg0_q,
  input  logic              rx_near_full,
  input  logic              tx_near_empty,
  input  logic              rx_has_data,
  input  logic              status_event
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0]   pins_s;
  logic               cs_n_s, sclk_s, mosi_s;
  cmd_t               cmd_q;
  logic               cmd_stb, data_stb, tx_bit, tx_oe, reg_we;
  logic [BYTE_W-1:0]  data_q, rd_data;
  logic [NUM_SRC-1:0] en_q, pend_q;

  spi2r_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, mosi}), .q(pins_s)
  );
  assign {cs_n_s, sclk_s, mosi_s} = pins_s;

  assign rd_data = cmd_q.sel_r1 ? r1_image(en_q, pend_q) : reg0_q;

  spi2r_link u_link (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .rd_data(rd_data), .cmd_q(cmd_q), .cmd_stb(cmd_stb),
    .data_stb(data_stb), .data_q(data_q), .err_pulse(cmd_err),
    .tx_bit(tx_bit), .tx_oe(tx_oe)
  );

  assign reg_we = data_stb & ~cmd_q.is_read & cmd_legal(cmd_q);

  spi2r_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(reg_we), .wr_sel_r1(cmd_q.sel_r1), .wr_data(data_q),
    .level_in({rx_has_data, tx_near_empty, rx_near_full}),
    .evt_in(status_event),
    .r0_q(reg0_q), .en_q(en_q), .pend_q(pend_q), .irq_n(irq_n)
  );

  assign miso_drive_en = tx_oe;
  assign miso = tx_oe ? tx_bit : 1'bz;

  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && !cmd_legal(cmd_q)) |-> !reg_we);
  a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q.is_read && !cmd_stb) |-> !miso_drive_en);
endmodule

// File: tb/spi_hostreg_if_bench.sv
module spi_hostreg_if_bench;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, mosi = 0;
  logic rx_near_full = 0, tx_near_empty = 0, rx_has_data = 0, status_event = 0;
  wire  miso;
  logic miso_drive_en, irq_n, cmd_err;
  logic [7:0] reg0_q;

  int total = 0, bad = 0, err_seen = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_got;
  logic       mon_oe_all, mon_oe_cmd;
  event       rd_done;

  always #5 clk = ~clk;

  spi_hostreg_if u_spi_hostreg_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_drive_en(miso_drive_en), .irq_n(irq_n),
    .cmd_err(cmd_err), .reg0_q(reg0_q), .rx_near_full(rx_near_full),
    .tx_near_empty(tx_near_empty), .rx_has_data(rx_has_data),
    .status_event(status_event)
  );

  always @(posedge clk) if (cmd_err) err_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                      output logic [7:0] got, output logic oe_cmd,
                      output logic oe_data_any, output logic oe_data_all);
    logic [15:0] frame;
    frame = {c, d};
    got = '0; oe_cmd = 0; oe_data_any = 0; oe_data_all = 1;
    @(negedge clk); cs_n = 0;
    waitc(6);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? frame[15-i] : 1'b1;
      waitc(5);
      if (i < 8) oe_cmd |= miso_drive_en;
      else if (i < 16) begin
        got = {got[6:0], miso};
        oe_data_any |= miso_drive_en;
        oe_data_all &= miso_drive_en;
      end
      waitc(1); sclk = 1;
      waitc(6); sclk = 0;
    end
    waitc(6); cs_n = 1;
    waitc(10);
  endtask

  task automatic rd(input logic [7:0] c, input logic [7:0] exp, input string tag);
    logic [7:0] g; logic oc, oa, ol;
    exp_q.push_back(exp); tag_q.push_back(tag);
    xfer(c, 8'h00, 16, g, oc, oa, ol);
    mon_got = g; mon_oe_all = ol; mon_oe_cmd = oc;
    ->rd_done;
    waitc(1);
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d, input int nbits,
                    input string tag);
    logic [7:0] g; logic oc, oa, ol;
    xfer(c, d, nbits, g, oc, oa, ol);
    chk(!oc && !oa, {tag, " R5 no drive in write"}, oa, 0);
  endtask

  always @(rd_done) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    chk(mon_got == e, {t, " read data"}, mon_got, e);
    chk(mon_oe_all && !mon_oe_cmd, {t, " R5 drive window"}, mon_oe_all, 1);
  end

  initial begin
    int e0;
    rst_n = 0; waitc(4); rst_n = 1; waitc(4);
    chk(reg0_q == 8'h00 && irq_n && !miso_drive_en, "R1 reset state",
        {reg0_q, irq_n, miso_drive_en}, 9'h002);
    rd(8'hC0, 8'hF0, "R1 R4 reset reg1");

    wr(8'h00, 8'hA5, 16, "R2");
    chk(reg0_q == 8'hA5, "R2 write reg0", reg0_q, 8'hA5);
    rd(8'h40, 8'hA5, "R3 read reg0");
    wr(8'h00, 8'h3C, 16, "R2b");
    rd(8'h40, 8'h3C, "R3 read reg0 second pattern");

    rx_near_full = 1; waitc(4);
    chk(irq_n == 0, "R10 irq on enabled flag", irq_n, 0);
    rd(8'hC0, 8'hF1, "R4 R8 reg1 rx_near_full");
    wr(8'h80, 8'h00, 16, "R10 mask");
    waitc(4);
    chk(irq_n == 1, "R10 mask hides flag", irq_n, 1);
    rd(8'hC0, 8'h01, "R10 mask readback");

    e0 = err_seen;
    wr(8'h01, 8'hFF, 16, "R6 illegal write");
    chk(reg0_q == 8'h3C, "R6 data ignored", reg0_q, 8'h3C);
    chk(err_seen == e0 + 1, "R6 error pulse", err_seen - e0, 1);
    wr(8'h41, 8'h00, 16, "R6 illegal read no drive");
    chk(err_seen == e0 + 2, "R6 error pulse on read", err_seen - e0, 2);

    wr(8'h00, 8'h77, 12, "R7 abort");
    chk(reg0_q == 8'h3C, "R7 aborted frame no update", reg0_q, 8'h3C);
    wr(8'h00, 8'h96, 16, "R11");
    chk(reg0_q == 8'h96, "R11 frame after abort", reg0_q, 8'h96);

    wr(8'h00, 8'h5A, 20, "R12");
    chk(reg0_q == 8'h5A, "R12 extra clocks ignored", reg0_q, 8'h5A);

    rx_near_full = 0; tx_near_empty = 1; rx_has_data = 1;
    @(negedge clk); status_event = 1; @(negedge clk); status_event = 0;
    waitc(4);
    rd(8'hC0, 8'h0E, "R8 R9 levels and event");
    wr(8'h80, 8'hF0, 16, "R9 keep");
    rd(8'hC0, 8'hFE, "R9 bit3 zero keeps event");
    chk(irq_n == 0, "R10 irq with enables back", irq_n, 0);
    wr(8'h80, 8'hF8, 16, "R9 clear");
    tx_near_empty = 0; rx_has_data = 0; waitc(4);
    rd(8'hC0, 8'hF0, "R9 event cleared");
    chk(irq_n == 1, "R10 irq released", irq_n, 1);
    chk(!miso_drive_en, "R5 idle no drive", miso_drive_en, 0);

    waitc(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule